// File: doc/BRIEF.md
# Handshaked Run-State Control Register

This block holds the operating state of a serial-port core and is the only place that state can change. Software writes a requested state through a simple write strobe. The current state goes straight to the datapath. A settled flag drops while a change takes effect and rises again after a fixed number of core clock cycles. Software must wait for the flag before it writes the next state. If the flag does not return within about ten polls, software treats the change as failed.

The state field has three legal codes: reset, run and pause. Code 2 is not a state. It is the clear command, and it only has a meaning in pause. Leaving pause for reset takes two clear writes in a row. The first write only arms a hidden pending condition. The second write completes the move. Any other accepted write in between cancels the pending condition. A write made before the block has settled changes nothing and sets a sticky illegal-write flag. A separate soft-reset strobe forces the block back to reset from any condition.

Top module: `run_state_reg`

## Requirements
- R1: After reset, `state_o` is 0, `settled_o` is 1, `illegal_o` is 0 and `rd_data_o` reads 0x04.
- R2: The state field is bits [1:0]. Code 0 is reset, 1 is run and 3 is pause. An accepted write of 0, 1 or 3 that differs from the current state moves `state_o` and `rd_data_o[1:0]` to that code on the next clock edge. `state_o` never shows 2.
- R3: After a write that changes the state, `settled_o` (also readable at `rd_data_o[2]`) reads 0 for exactly SETTLE_CYCLES cycles and then reads 1.
- R4: An accepted write that requests the current state, or a write of 2 outside pause, leaves the state unchanged and keeps `settled_o` at 1.
- R5: Bits [DATA_W-1:3] are stored from every accepted write, except a write that cancels a pending clear. They read back unchanged. Bit 2 of the write data is ignored.
- R6: A write made while `settled_o` is 0 has no effect on the state and sets `illegal_o`. `illegal_o` stays set until a soft reset.
- R7: In pause, a single write of 2 leaves `state_o` at 3 and `settled_o` at 1.
- R8: In pause, two consecutive accepted writes of 2 move the state to 0, with the R3 settle window.
- R9: After one write of 2 in pause, any accepted write with another code cancels the pending clear. The state stays at pause, with no settle window. After a cancel, one further write of 2 alone does not reach reset.
- R10: A pulse on `sw_rst_i` takes priority over a write in the same cycle. On the next cycle the state is 0, `settled_o` is 1, `illegal_o` is 0, the stored upper bits are 0 and any pending clear is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the state register |
| wr_data_i | input | DATA_W | Write data; [1:0] is the state request |
| sw_rst_i | input | 1 | Soft-reset write strobe |
| rd_data_o | output | DATA_W | Readback: upper bits, settled flag at bit 2, state at [1:0] |
| state_o | output | 2 | Current state to the datapath |
| settled_o | output | 1 | 1 when the state has settled and writes are accepted |
| illegal_o | output | 1 | Sticky flag for a write made while unsettled |

## Verification
The pending clear is not visible at any port. In pause it reads exactly like plain pause. It can only be seen through what a later write does. The bench therefore arms it with one clear write and cancels it with a run write. It then shows that the cancel took effect: a single clear write afterwards leaves the block in pause, and only a second one reaches reset. A write inside the settle window is made by issuing the next write one cycle after a state change.

// File: rtl/run_state_pkg.sv
package run_state_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_RUN   = 2'd1,
    ST_CLEAR = 2'd2,  // command code only, never a held state
    ST_PAUSE = 2'd3
  } run_state_e;
endpackage

// File: rtl/run_settle_ctr.sv
module run_settle_ctr #(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clear_i,
  output logic settled_o
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clear_i)       cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(SETTLE_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign settled_o = (cnt_q == '0);

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(SETTLE_CYCLES));
  a_r3_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !start_i && !clear_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/run_state_fsm.sv
module run_state_fsm
  import run_state_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sw_rst_i,
  input  logic              settled_i,
  output logic [1:0]        state_o,
  output logic [DATA_W-4:0] upper_o,
  output logic              start_o,
  output logic              illegal_o
);
  localparam int UW = DATA_W - 3;

  run_state_e    state_q, state_d;
  logic          pend_q, pend_d;
  logic [UW-1:0] upper_q, upper_d;
  logic          illegal_q;
  logic          acc, bad;
  logic [1:0]    req;

  assign acc = wr_en_i && settled_i && !sw_rst_i;
  assign bad = wr_en_i && !settled_i && !sw_rst_i;
  assign req = wr_data_i[1:0];

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    upper_d = upper_q;
    start_o = 1'b0;
    if (acc) begin
      if (pend_q) begin
        pend_d = 1'b0;
        if (req == ST_CLEAR) begin
          state_d = ST_RESET;
          upper_d = wr_data_i[DATA_W-1:3];
          start_o = 1'b1;
        end
      end else begin
        upper_d = wr_data_i[DATA_W-1:3];
        if (req == ST_CLEAR) begin
          if (state_q == ST_PAUSE) pend_d = 1'b1;
        end else if (req != state_q) begin
          state_d = run_state_e'(req);
          start_o = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RESET;
      pend_q    <= 1'b0;
      upper_q   <= '0;
      illegal_q <= 1'b0;
    end else if (sw_rst_i) begin
      state_q   <= ST_RESET;
      pend_q    <= 1'b0;
      upper_q   <= '0;
      illegal_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      pend_q    <= pend_d;
      upper_q   <= upper_d;
      if (bad) illegal_q <= 1'b1;
    end
  end

  assign state_o   = state_q;
  assign upper_o   = upper_q;
  assign illegal_o = illegal_q;

  a_r7_arm_keeps_pause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !pend_q && state_q == ST_PAUSE && req == ST_CLEAR)
      |=> (pend_q && state_q == ST_PAUSE && settled_i));
  a_r8_pend_in_pause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> state_q == ST_PAUSE);
  a_r9_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && pend_q && req != ST_CLEAR) |=> (!pend_q && state_q == ST_PAUSE));
endmodule

// File: rtl/run_state_reg.sv
module run_state_reg #(
  parameter int DATA_W        = 8,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sw_rst_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [1:0]        state_o,
  output logic              settled_o,
  output logic              illegal_o
);
  localparam int UW = DATA_W - 3;

  logic          start;
  logic [UW-1:0] upper;

  run_settle_ctr #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .clear_i   (sw_rst_i),
    .settled_o (settled_o)
  );

  run_state_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .sw_rst_i  (sw_rst_i),
    .settled_i (settled_o),
    .state_o   (state_o),
    .upper_o   (upper),
    .start_o   (start),
    .illegal_o (illegal_o)
  );

  assign rd_data_o = {upper, settled_o, state_o};

  a_r2_no_code2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd2);
  a_r3_change_unsettled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != $past(state_o) && !$past(sw_rst_i)) |-> !settled_o);
  a_r6_ignored_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !settled_o && !sw_rst_i) |=> (illegal_o && $stable(state_o)));
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o && !sw_rst_i) |=> illegal_o);
  a_r10_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> (state_o == 2'd0 && settled_o && !illegal_o));
endmodule

// File: tb/run_state_reg_test.sv
module run_state_reg_test;
  localparam int DATA_W = 8;
  localparam int SETTLE = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              sw_rst = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic [1:0]        state;
  logic              settled;
  logic              illegal;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  run_state_reg #(.DATA_W(DATA_W), .SETTLE_CYCLES(SETTLE)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .sw_rst_i  (sw_rst),
    .rd_data_o (rd_data),
    .state_o   (state),
    .settled_o (settled),
    .illegal_o (illegal)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // counts unsettled cycles, starting at the current sample point
  task automatic wait_settle(output int n);
    n = 0;
    while (!settled && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic soft_reset_with_write(input logic [DATA_W-1:0] d);
    @(negedge clk);
    sw_rst = 1'b1;
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    sw_rst = 1'b0;
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 state", state, 0);
    chk("R1 settled", settled, 1);
    chk("R1 illegal", illegal, 0);
    chk("R1 rd_data", rd_data, 8'h04);
  endtask

  task automatic t_encoding();
    int n;
    do_write(8'h01);
    chk("R2 run state", state, 1);
    chk("R2 run readback", rd_data[1:0], 1);
    chk("R3 drop", settled, 0);
    chk("R3 drop at bit2", rd_data[2], 0);
    wait_settle(n);
    chk("R3 window run", n, SETTLE);
    do_write(8'h03);
    chk("R2 pause state", state, 3);
    wait_settle(n);
    chk("R3 window pause", n, SETTLE);
    do_write(8'h00);
    chk("R2 reset state", state, 0);
    wait_settle(n);
    chk("R3 window reset", n, SETTLE);
    chk("R3 settled bit2", rd_data[2], 1);
  endtask

  task automatic t_nochange();
    do_write(8'hA8);
    chk("R4 same state settled", settled, 1);
    chk("R5 upper stored", rd_data, 8'hAC);
    do_write(8'hF2);
    chk("R4 code2 outside pause state", state, 0);
    chk("R4 code2 outside pause settled", settled, 1);
    chk("R5 upper stored again", rd_data, 8'hF4);
    do_write(8'h04);
    chk("R5 bit2 ignored", rd_data, 8'h04);
  endtask

  task automatic t_illegal();
    int n;
    do_write(8'h01);
    do_write(8'h03);
    chk("R6 state unchanged", state, 1);
    chk("R6 illegal set", illegal, 1);
    wait_settle(n);
    chk("R6 sticky", illegal, 1);
    chk("R6 state still run", state, 1);
  endtask

  task automatic t_soft_reset();
    do_write(8'hF9);
    soft_reset_with_write(8'h03);
    chk("R10 state", state, 0);
    chk("R10 settled", settled, 1);
    chk("R10 illegal cleared", illegal, 0);
    chk("R10 readback", rd_data, 8'h04);
  endtask

  task automatic go_pause();
    int n;
    do_write(8'h03);
    wait_settle(n);
  endtask

  task automatic t_pause_exit();
    int n;
    go_pause();
    do_write(8'h02);
    chk("R7 still pause", state, 3);
    chk("R7 settled", settled, 1);
    chk("R7 readback", rd_data[1:0], 3);
    do_write(8'h02);
    chk("R8 reached reset", state, 0);
    chk("R8 unsettled", settled, 0);
    wait_settle(n);
    chk("R8 window", n, SETTLE);
  endtask

  task automatic t_cancel();
    int n;
    go_pause();
    do_write(8'h02);
    do_write(8'h01);
    chk("R9 cancel keeps pause", state, 3);
    chk("R9 cancel no settle", settled, 1);
    do_write(8'h02);
    chk("R9 single clear after cancel", state, 3);
    do_write(8'h02);
    chk("R9 second clear resets", state, 0);
    wait_settle(n);
    chk("R9 settles", settled, 1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_encoding();
    t_nochange();
    t_illegal();
    t_soft_reset();
    t_pause_exit();
    t_cancel();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule